// File: doc/BRIEF.md
# UART interrupt identification and prioritisation unit

This block sits between the status logic of a serial port (receive FIFO, line error detection, transmit FIFO, modem line change detection) and the host. It keeps one pending flag per interrupt source and gates each flag with its own enable bit. It drives a single interrupt request, together with an 8-bit identification byte that names the most urgent source that is enabled and pending. The serial engines and the bus decoding are outside the block. Those neighbours supply one-cycle strobes for register reads, FIFO pushes and pops, error detections and character-time ticks.

The block also contains the receive character-timeout counter. It counts character-time ticks while the receive FIFO holds data and nothing enters or leaves it. Each source has its own clearing event. Line errors clear when the line status register is read. Modem changes clear when the modem status register is read. A timeout clears when the receive buffer is read. Transmit-empty clears when the transmit FIFO is written, or when the identification byte is read while it reports transmit-empty.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous active-low reset, with all inputs low and `rx_count` zero, `ident` reads C1h and `irq` is 0.
- R2: `ident[7:6]` always read 11 and `ident[5:4]` read 00. `ident[0]` is 0 exactly when some enabled source is pending, and `irq` is 1 exactly then.
- R3: A source counts only when its enable bit is set. The enable bits are `ien[0]` for received data and timeout, `ien[1]` for transmit-empty, `ien[2]` for line status and `ien[3]` for modem status. A pending flag whose enable is clear is kept, and it appears once the enable bit is set.
- R4: `ident[3:1]` names the winning source with these codes: 011 line status, 110 timeout, 010 data available, 001 transmit-empty, 000 modem status. The winner is chosen in that order. Timeout is reported in preference to data available. When nothing is pending the field reads 000.
- R5: Any bit of `err_flags` high on a clock edge sets the line-status flag. `rd_line` clears it at that edge. When both occur at the same edge, the set takes effect.
- R6: Data available is a level: `rx_count` is at least the trigger level. `trig_code` values 00, 01, 10 and 11 select 1, 4, 8 and 14 bytes.
- R7: The timeout flag sets on the 4th `char_tick` during which `rx_count` was non-zero and no `rx_push` or `rx_read` occurred. A push, a read or an empty FIFO restarts the count. Only `rx_read` clears the flag.
- R8: A rising edge of `tx_empty` sets the transmit-empty flag. `tx_write` clears it, and the clear wins over a simultaneous set.
- R9: `rd_ident` clears the transmit-empty flag only while `ident[3:1]` reports 001 with `ident[0]` at 0. A read that reports another source leaves the flag pending.
- R10: Any bit of `modem_delta` sets the modem-status flag. `rd_modem` clears it, and the set wins when both occur at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien | input | 4 | Per-source enable bits |
| err_flags | input | 4 | Overrun, parity, framing and break detection strobes |
| rd_line | input | 1 | Line status register read strobe |
| rx_count | input | CNT_W | Characters currently in the receive FIFO |
| trig_code | input | 2 | Receive trigger level selection |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_read | input | 1 | Receive buffer read (pop) strobe |
| char_tick | input | 1 | One pulse per character time |
| tx_empty | input | 1 | Transmit FIFO empty level |
| tx_write | input | 1 | Transmit FIFO write strobe |
| modem_delta | input | 4 | Modem line change strobes |
| rd_modem | input | 1 | Modem status register read strobe |
| rd_ident | input | 1 | Identification byte read strobe |
| irq | output | 1 | Interrupt request, active high |
| ident | output | 8 | Identification byte |

## Verification
The assertions assume that `rx_count` never exceeds the FIFO depth. They also assume that every strobe is a clean synchronous level for one cycle, so a read of the identification byte is judged against the value shown in that same cycle. The random stimulus keeps `rx_count` between zero and the depth. It drives every input at the falling clock edge. It keeps strobe densities low enough that timeouts, transmit-empty edges and coincident set and clear events all occur, and the directed cases place the trigger boundaries and the fourth idle tick exactly.

// File: rtl/uart_irq_pkg.sv
// Shared types for the UART interrupt identification unit.
// Assumes: source codes are decoded by software, so their values are fixed.
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_MODEM   = 3'b000,
        SRC_TXEMPTY = 3'b001,
        SRC_RXDATA  = 3'b010,
        SRC_LINE    = 3'b011,
        SRC_TIMEOUT = 3'b110
    } irq_src_e;

    // Receive trigger level in bytes for a 2-bit selection code.
    function automatic int unsigned trig_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_flags.sv
// Pending flags for line status, modem status and transmit-empty sources.
// Assumes: all inputs are synchronous one-cycle strobes except tx_empty (a level).
module uart_irq_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] err_flags,
    input  logic       rd_line,
    input  logic [3:0] modem_delta,
    input  logic       rd_modem,
    input  logic       tx_empty,
    input  logic       tx_write,
    input  logic       te_ack,
    output logic       ls_pend,
    output logic       ms_pend,
    output logic       te_pend
);
    logic tx_empty_q;
    logic err_any;
    logic delta_any;

    assign err_any   = |err_flags;
    assign delta_any = |modem_delta;

    // Line status flag: any error sets, a line status read clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        ls_pend <= 1'b0;
        else if (err_any)  ls_pend <= 1'b1;
        else if (rd_line)  ls_pend <= 1'b0;
    end

    // Modem flag: any line change sets, a modem status read clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         ms_pend <= 1'b0;
        else if (delta_any) ms_pend <= 1'b1;
        else if (rd_modem)  ms_pend <= 1'b0;
    end

    // Edge detector history for tx_empty; starts high so reset makes no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_empty_q <= 1'b1;
        else        tx_empty_q <= tx_empty;
    end

    // Transmit-empty flag: write or acknowledged read clears, rising edge sets.
    always_ff @(posedge clk) begin
        if (!rst_n)                      te_pend <= 1'b0;
        else if (tx_write || te_ack)     te_pend <= 1'b0;
        else if (tx_empty && !tx_empty_q) te_pend <= 1'b1;
    end

    // R5
    ls_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_line && !err_any) |=> !ls_pend);
    // R10
    ms_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delta_any |=> ms_pend);
    // R8
    te_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !te_pend);

endmodule

// File: rtl/uart_irq_timeout.sv
// Receive character-timeout detector: counts idle character ticks while
// the receive FIFO holds data and raises a flag after IDLE_CHARS of them.
// Assumes: char_tick is one cycle wide; rx_count never exceeds the depth.
module uart_irq_timeout #(
    parameter int CNT_W      = 5,
    parameter int IDLE_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_read,
    input  logic             char_tick,
    output logic             to_pend
);
    localparam int TW = $clog2(IDLE_CHARS + 1);
    localparam logic [TW-1:0] LAST = TW'(IDLE_CHARS - 1);
    localparam logic [TW-1:0] FULL = TW'(IDLE_CHARS);

    logic [TW-1:0] idle_cnt;
    logic          restart;
    logic          fire;

    assign restart = rx_push || rx_read || (rx_count == '0);
    assign fire    = char_tick && !restart && (idle_cnt == LAST);

    // Idle tick counter, saturating at IDLE_CHARS, restarted by FIFO activity.
    always_ff @(posedge clk) begin
        if (!rst_n)                          idle_cnt <= '0;
        else if (restart)                    idle_cnt <= '0;
        else if (char_tick && idle_cnt != FULL) idle_cnt <= idle_cnt + 1'b1;
    end

    // Timeout flag: receive buffer read clears, the final idle tick sets.
    always_ff @(posedge clk) begin
        if (!rst_n)       to_pend <= 1'b0;
        else if (rx_read) to_pend <= 1'b0;
        else if (fire)    to_pend <= 1'b1;
    end

    // R7
    idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= FULL);
    // R7
    to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_pend) |-> ($past(rx_count) != '0 && $past(char_tick)));
    // R7
    to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read |=> !to_pend);

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: picks the most urgent enabled pending source.
// Assumes: inputs are already gated by their enable bits.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic     ls,
    input  logic     to,
    input  logic     da,
    input  logic     te,
    input  logic     ms,
    output logic     any,
    output irq_src_e src
);
    // Priority chain: line status, timeout, data, transmit-empty, modem.
    always_comb begin
        any = 1'b1;
        if (ls)      src = SRC_LINE;
        else if (to) src = SRC_TIMEOUT;
        else if (da) src = SRC_RXDATA;
        else if (te) src = SRC_TXEMPTY;
        else begin
            src = SRC_MODEM;
            any = ms;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
// UART interrupt identification unit (top): gates the source flags with
// their enables, forms the identification byte and the interrupt request.
// Assumes: strobes are synchronous and one cycle wide; rx_count <= FIFO_DEPTH.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int IDLE_CHARS = 4,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ien,
    input  logic [3:0]       err_flags,
    input  logic             rd_line,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_code,
    input  logic             rx_push,
    input  logic             rx_read,
    input  logic             char_tick,
    input  logic             tx_empty,
    input  logic             tx_write,
    input  logic [3:0]       modem_delta,
    input  logic             rd_modem,
    input  logic             rd_ident,
    output logic             irq,
    output logic [7:0]       ident
);
    logic       ls_pend, ms_pend, te_pend, to_pend;
    logic       da_lvl;
    logic       te_ack;
    logic       any;
    irq_src_e   src;
    logic [CNT_W-1:0] trig_lvl;

    assign trig_lvl = CNT_W'(trig_bytes(trig_code));
    assign da_lvl   = (rx_count >= trig_lvl);
    assign te_ack   = rd_ident && any && (src == SRC_TXEMPTY);

    uart_irq_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_flags   (err_flags),
        .rd_line     (rd_line),
        .modem_delta (modem_delta),
        .rd_modem    (rd_modem),
        .tx_empty    (tx_empty),
        .tx_write    (tx_write),
        .te_ack      (te_ack),
        .ls_pend     (ls_pend),
        .ms_pend     (ms_pend),
        .te_pend     (te_pend)
    );

    uart_irq_timeout #(
        .CNT_W      (CNT_W),
        .IDLE_CHARS (IDLE_CHARS)
    ) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_count  (rx_count),
        .rx_push   (rx_push),
        .rx_read   (rx_read),
        .char_tick (char_tick),
        .to_pend   (to_pend)
    );

    uart_irq_prio u_prio (
        .ls  (ls_pend && ien[2]),
        .to  (to_pend && ien[0]),
        .da  (da_lvl  && ien[0]),
        .te  (te_pend && ien[1]),
        .ms  (ms_pend && ien[3]),
        .any (any),
        .src (src)
    );

    assign irq   = any;
    assign ident = {2'b11, 2'b00, src, ~any};

    // R4
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[2] && ls_pend) |-> (ident[3:1] == 3'b011));
    // R9
    te_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ident && ident[3:1] == 3'b001 && !ident[0] && !tx_write) |=> !te_pend);
    // R3
    masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 4'b0000) |-> (!irq && ident == 8'hC1));

endmodule

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/100ps
module tb_uart_irq_ident;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    ien = '0, err_flags = '0, modem_delta = '0;
    logic          rd_line = 0, rx_push = 0, rx_read = 0, char_tick = 0;
    logic          tx_empty = 0, tx_write = 0, rd_modem = 0, rd_ident = 0;
    logic [CW-1:0] rx_count = '0;
    logic [1:0]    trig_code = '0;
    logic          irq;
    logic [7:0]    ident;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit m_ls, m_ms, m_te, m_to, m_txq;
    int m_idle;

    always #2.5 clk = ~clk;

    uart_irq_ident #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ien(ien), .err_flags(err_flags),
        .rd_line(rd_line), .rx_count(rx_count), .trig_code(trig_code),
        .rx_push(rx_push), .rx_read(rx_read), .char_tick(char_tick),
        .tx_empty(tx_empty), .tx_write(tx_write), .modem_delta(modem_delta),
        .rd_modem(rd_modem), .rd_ident(rd_ident), .irq(irq), .ident(ident)
    );

    function automatic int lvl(input logic [1:0] c);
        case (c) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
    endfunction

    function automatic logic [7:0] exp_ident();
        logic [2:0] code;
        bit p;
        p = 1;
        if (m_ls && ien[2])                       code = 3'b011;
        else if (m_to && ien[0])                  code = 3'b110;
        else if (int'(rx_count) >= lvl(trig_code) && ien[0]) code = 3'b010;
        else if (m_te && ien[1])                  code = 3'b001;
        else begin code = 3'b000; p = m_ms && ien[3]; end
        return {4'b1100, code, ~p};
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model advance for one clock edge using the inputs now applied.
    task automatic model_edge();
        logic [7:0] e;
        bit restart;
        e = exp_ident();
        if (|err_flags) m_ls = 1; else if (rd_line) m_ls = 0;
        if (|modem_delta) m_ms = 1; else if (rd_modem) m_ms = 0;
        if (tx_write || (rd_ident && e[3:1] == 3'b001 && !e[0])) m_te = 0;
        else if (tx_empty && !m_txq) m_te = 1;
        m_txq = tx_empty;
        restart = rx_push || rx_read || rx_count == 0;
        if (rx_read) m_to = 0;
        else if (char_tick && !restart && m_idle == 3) m_to = 1;
        if (restart) m_idle = 0;
        else if (char_tick && m_idle < 4) m_idle++;
    endtask

    // Compare outputs with the model, advance it, wait for the next drive point.
    task automatic run();
        logic [7:0] e;
        #0.5;
        e = exp_ident();
        check(ident, e, "R4 ident");
        check({7'd0, irq}, {7'd0, ~e[0]}, "R2 irq");
        model_edge();
        @(negedge clk);
    endtask

    task automatic clr();
        err_flags = 0; modem_delta = 0; rd_line = 0; rx_push = 0; rx_read = 0;
        char_tick = 0; tx_write = 0; rd_modem = 0; rd_ident = 0;
    endtask

    task automatic now(input logic [7:0] exp, input string tag);
        #0.2;
        check(ident, exp, tag);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_txq = 1; m_ls = 0; m_ms = 0; m_te = 0; m_to = 0; m_idle = 0;

        // R1 reset state
        now(8'hC1, "R1 reset ident");
        check({7'd0, irq}, 8'd0, "R1 reset irq");
        run();

        // R6 trigger boundaries
        ien = 4'b0001; trig_code = 2'b01; rx_count = 3; now(8'hC1, "R6 3 below 4"); run();
        rx_count = 4;  now(8'hC4, "R6 4 at 4"); run();
        trig_code = 2'b11; rx_count = 13; now(8'hC1, "R6 13 below 14"); run();
        rx_count = 14; now(8'hC4, "R6 14 at 14"); run();
        trig_code = 2'b00; rx_count = 1; now(8'hC4, "R6 1 at 1"); run();
        trig_code = 2'b10; rx_count = 7; now(8'hC1, "R6 7 below 8"); run();

        // R7 timeout after 4 idle ticks, cleared by read
        trig_code = 2'b11; rx_count = 2;
        for (int i = 0; i < 3; i++) begin char_tick = 1; run(); clr(); now(8'hC1, "R7 before 4th tick"); run(); end
        char_tick = 1; run(); clr(); now(8'hCC, "R7 after 4th tick");
        rx_push = 1; rx_count = 3; run(); clr(); now(8'hCC, "R7 push keeps flag");
        rx_read = 1; rx_count = 2; run(); clr(); now(8'hC1, "R7 read clears");
        run();

        // R4 priority walk with all sources
        ien = 4'hF; err_flags = 4'b0100; modem_delta = 4'b0001; tx_empty = 1; rx_count = 14;
        run(); clr(); now(8'hC6, "R4 line status first");
        rd_line = 1; run(); clr(); now(8'hC4, "R5 rd_line clears, data next");
        rx_count = 0; now(8'hC2, "R4 transmit empty third");
        // R9 rd_ident clears transmit-empty when reported
        rd_ident = 1; run(); clr(); now(8'hC0, "R9 ident read clears, modem last");
        rd_modem = 1; run(); clr(); now(8'hC1, "R10 rd_modem clears");

        // R9 ident read while line status reported leaves transmit-empty
        tx_empty = 0; run(); tx_empty = 1; err_flags = 4'b0001; run(); clr();
        now(8'hC6, "R9 line status shown");
        rd_ident = 1; run(); clr(); rd_line = 1; run(); clr();
        now(8'hC2, "R9 transmit-empty kept");
        // R8 write clears
        tx_write = 1; run(); clr(); now(8'hC1, "R8 tx_write clears");

        // R3 masked pending flag appears when enabled
        ien = 4'b0000; modem_delta = 4'b1000; run(); clr();
        now(8'hC1, "R3 masked modem"); check({7'd0, irq}, 8'd0, "R3 masked irq");
        ien = 4'b1000; now(8'hC0, "R3 enabled modem");
        // R5 set wins over clear
        ien = 4'b0100; err_flags = 4'b1000; rd_line = 1; run(); clr();
        now(8'hC6, "R5 set wins");
        rd_line = 1; rd_modem = 1; run(); clr();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            clr();
            if ($urandom_range(99) < 5)  err_flags   = 4'($urandom());
            if ($urandom_range(99) < 10) rd_line     = 1;
            if ($urandom_range(99) < 5)  modem_delta = 4'($urandom());
            if ($urandom_range(99) < 10) rd_modem    = 1;
            if ($urandom_range(99) < 10) tx_empty    = ~tx_empty;
            if ($urandom_range(99) < 5)  tx_write    = 1;
            if ($urandom_range(99) < 15) rd_ident    = 1;
            if ($urandom_range(99) < 30) char_tick   = 1;
            if ($urandom_range(99) < 4)  rx_push     = 1;
            if ($urandom_range(99) < 4)  rx_read     = 1;
            if ($urandom_range(99) < 8)  rx_count    = CW'($urandom_range(DEPTH));
            if ($urandom_range(99) < 3)  trig_code   = 2'($urandom());
            if ($urandom_range(99) < 3)  ien         = 4'($urandom());
            run();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule